// File: doc/BRIEF.md
# Machine-Cycle Sequencer with Bus-Idle Cycles

This block runs the external bus of a small 8-bit processor, one T state per clock. The core asks for the next machine cycle through a request port that carries a kind, a 16-bit address and write data. The block then walks the T states of that cycle and drives the bus pins: the address-latch strobe, the active-low read and write strobes, a two-bit cycle-status code, the high address byte, and the shared low-address/data byte with its output enable. In read and fetch cycles it captures the returning data byte. A slow peripheral can stretch read, write and fetch cycles by holding READY low.

Some operations need more internal time than a four-state fetch provides, such as a 16-bit register-pair add that needs six extra states. The core requests these as a long fetch. The fetch itself keeps its normal four states. The block then adds `N_IDLE` (default 2) bus-idle machine cycles. Each of these has the timing of a read cycle, but it raises no strobe, drives nothing onto the shared byte and never waits on READY. The core cannot place a new request until the last of these idle cycles ends.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block is in reset. After that edge, `tstate` is 0 (no cycle in progress), `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `status` is 0 and `rdata_valid` is 0. With no cycle in progress, `req_ready` is 1 and `addr_hi` is 0.
- R2: `req_kind` 0 (fetch) gives the T-state sequence T1, T2, T3, T4. The `tstate` codes are 1, 2, 3, 4, and 5 stands for a wait state. During the cycle `status` is 3. `ale` is 1 only in T1, and in T1 `ad_out` carries the low address byte with `ad_oe` set. `rd_n` is low in T2, in any wait state and in T3.
- R3: `req_kind` 1 (read) gives T1, T2, T3 with `status` 2 and the same strobe timing as a fetch. In a read or a fetch, `ad_in` is sampled at the edge that ends T3. The next clock shows the sampled value on `rdata` with `rdata_valid` high for exactly that one clock.
- R4: `req_kind` 2 (write) gives T1, T2, T3 with `status` 1. `wr_n` is low and `ad_out` carries the write data with `ad_oe` set in T2, in any wait state and in T3. `rd_n` stays high.
- R5: In a fetch, read or write, READY is sampled at the end of T2 and at the end of each wait state. While it is low, another wait state (code 5) follows. Once it is high, T3 follows.
- R6: `req_kind` 3 (long fetch) gives a normal fetch followed directly by `N_IDLE` bus-idle cycles. Each idle cycle is T1, T2, T3 with `status` 0, and `addr_hi` still holds the fetch address.
- R7: During a bus-idle cycle `ale` stays 0, `rd_n` and `wr_n` stay 1 and `ad_oe` stays 0.
- R8: READY has no effect in a bus-idle cycle: T3 always follows T2.
- R9: `req_ready` is 1 when no cycle is in progress, and in the last T state of a cycle with no idle cycle still to come. It is 0 at all other times. A request accepted in a last T state starts its T1 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core offers the next machine cycle |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 long fetch |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Data for a write cycle |
| req_ready | output | 1 | Request is taken at this clock edge |
| ready | input | 1 | Bus READY from slow devices |
| ad_in | input | 8 | Shared byte as read from the bus |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| status | output | 2 | Cycle type: 3 fetch, 2 read, 1 write, 0 idle or none |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared byte driven out (address low or write data) |
| ad_oe | output | 1 | Output enable for `ad_out` |
| rdata | output | 8 | Captured read or fetch data |
| rdata_valid | output | 1 | One-clock flag for `rdata` |
| tstate | output | 3 | Current T state: 0 none, 1-4 T1-T4, 5 wait |

## Verification
An accepted request shows T1 one clock after the edge that took it. T2 follows one clock later. Each READY value sampled at the end of T2 or of a wait state decides the state of the very next clock, and read data appears one clock after T3. The reference model in the bench lays out the whole expected pin trace of a cycle, slot by slot, at the moment of acceptance. It uses the READY values that the bench itself has planned for future clocks. Pins, `req_ready` and the read data are then compared against that trace in the middle of every clock, so a wait state that is missing or extra shows up at its exact slot. READY-low windows are placed on fetch, read and write T2 states and across both idle cycles, and one long fetch is followed directly by a read.

// File: rtl/bus_seq_pkg.sv
// Package: shared encodings for the machine-cycle sequencer.
// Assumes one clock per T state; the values of tstate_e and cyc_e are
// visible at the top-level ports and must not be renumbered.
package bus_seq_pkg;

    typedef enum logic [2:0] {
        TS_NONE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_T4   = 3'd4,
        TS_TW   = 3'd5
    } tstate_e;

    typedef enum logic [1:0] {
        CY_IDLE  = 2'b00,
        CY_WRITE = 2'b01,
        CY_READ  = 2'b10,
        CY_FETCH = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        RQ_FETCH      = 2'd0,
        RQ_READ       = 2'd1,
        RQ_WRITE      = 2'd2,
        RQ_FETCH_LONG = 2'd3
    } req_e;

    // Map a request code to the bus cycle it opens with.
    function automatic cyc_e req_to_cyc(input logic [1:0] code);
        case (code)
            RQ_READ:  return CY_READ;
            RQ_WRITE: return CY_WRITE;
            default:  return CY_FETCH;
        endcase
    endfunction

    // True in the states where a read or write strobe may be active.
    function automatic logic in_strobe_phase(input tstate_e t);
        return (t == TS_T2) || (t == TS_TW) || (t == TS_T3);
    endfunction

endpackage

// File: rtl/bus_seq_tctl.sv
// T-state controller: steps through T1..T4 and wait states, and appends
// bus-idle cycles after a long fetch. It decides when a request may be taken.
// Assumes READY is synchronous to clk; bus-idle cycles never look at it.
module bus_seq_tctl
    import bus_seq_pkg::*;
#(
    parameter int N_IDLE      = 2,
    parameter bit FETCH_WAITS = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic       ready,
    output tstate_e    tst,
    output cyc_e       cyc,
    output logic       req_ready,
    output logic       accept
);

    localparam int CNT_W = (N_IDLE < 1) ? 1 : $clog2(N_IDLE + 1);
    localparam logic [CNT_W-1:0] IDLE_LOAD = CNT_W'(N_IDLE);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    logic [CNT_W-1:0] idle_left;
    logic [CNT_W-1:0] idle_nx;
    tstate_e          tst_nx;
    cyc_e             cyc_nx;
    logic             last_t;
    logic             more_idle;
    logic             honour_rdy;

    // Pick which cycle kinds may be stretched by READY.
    generate
        if (FETCH_WAITS) begin : g_fetch_waits
            assign honour_rdy = (cyc != CY_IDLE);
        end else begin : g_fetch_nowait
            assign honour_rdy = (cyc == CY_READ) || (cyc == CY_WRITE);
        end
    endgenerate

    // Last T state of the current machine cycle.
    assign last_t    = (tst == TS_T4) || ((tst == TS_T3) && (cyc != CY_FETCH));
    assign more_idle = (idle_left != '0);
    assign req_ready = (tst == TS_NONE) || (last_t && !more_idle);
    assign accept    = req_valid && req_ready;

    // Next T state, cycle kind and pending idle count.
    always_comb begin
        tst_nx  = tst;
        cyc_nx  = cyc;
        idle_nx = idle_left;
        case (tst)
            TS_T1:        tst_nx = TS_T2;
            TS_T2, TS_TW: tst_nx = (honour_rdy && !ready) ? TS_TW : TS_T3;
            TS_T3:        if (cyc == CY_FETCH) tst_nx = TS_T4;
            default:      ;
        endcase
        if (accept) begin
            tst_nx  = TS_T1;
            cyc_nx  = req_to_cyc(req_kind);
            idle_nx = (req_kind == RQ_FETCH_LONG) ? IDLE_LOAD : '0;
        end else if (last_t && more_idle) begin
            tst_nx  = TS_T1;
            cyc_nx  = CY_IDLE;
            idle_nx = idle_left - CNT_ONE;
        end else if (last_t || (tst == TS_NONE)) begin
            tst_nx  = TS_NONE;
            cyc_nx  = CY_IDLE;
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tst       <= TS_NONE;
            cyc       <= CY_IDLE;
            idle_left <= '0;
        end else begin
            tst       <= tst_nx;
            cyc       <= cyc_nx;
            idle_left <= idle_nx;
        end
    end

endmodule

// File: rtl/bus_seq_latch.sv
// Request latch: holds address and write data of the accepted request for
// the whole machine cycle and any idle cycles that follow it.
module bus_seq_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    // Capture on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

endmodule

// File: rtl/bus_seq_pins.sv
// Pin driver: decodes T state and cycle kind into the bus strobes, status
// code and address/data drive. Purely combinational from registered state,
// so every pin changes only just after a clock edge.
module bus_seq_pins
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  tstate_e                  tst,
    input  cyc_e                     cyc,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [1:0]               status,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic active;
    logic bus_cyc;
    logic strobe_ph;
    logic is_rd;
    logic is_wr;

    assign active    = (tst != TS_NONE);
    assign bus_cyc   = active && (cyc != CY_IDLE);
    assign strobe_ph = in_strobe_phase(tst);
    assign is_rd     = (cyc == CY_FETCH) || (cyc == CY_READ);
    assign is_wr     = (cyc == CY_WRITE);

    // Strobes: latch pulse in T1, data strobes from T2 through T3.
    always_comb begin
        ale  = bus_cyc && (tst == TS_T1);
        rd_n = !(strobe_ph && is_rd);
        wr_n = !(strobe_ph && is_wr);
    end

    // Status and high address byte, held for the whole cycle.
    always_comb begin
        status  = active ? 2'(cyc) : 2'b00;
        addr_hi = active ? addr_q[ADDR_W-1 -: HI_W] : '0;
    end

    // Shared byte: low address in T1, write data during the write strobe.
    always_comb begin
        ad_oe  = ale || (strobe_ph && is_wr);
        ad_out = '0;
        if (ale)
            ad_out = addr_q[DATA_W-1:0];
        else if (ad_oe)
            ad_out = wdata_q;
    end

endmodule

// File: rtl/bus_seq_rcap.sv
// Read capture: samples the shared byte at the edge that ends T3 of a
// fetch or read cycle, and flags it for the next clock only.
module bus_seq_rcap
    import bus_seq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tstate_e           tst,
    input  cyc_e              cyc,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);

    logic take;

    assign take = (tst == TS_T3) && ((cyc == CY_FETCH) || (cyc == CY_READ));

    // Capture register and one-clock valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= take;
            if (take)
                rdata <= ad_in;
        end
    end

endmodule

// File: rtl/bus_cycle_seq.sv
// Top: machine-cycle sequencer. Takes one request per machine cycle and
// drives the bus pins T state by T state. A long fetch is followed by
// N_IDLE bus-idle cycles that raise no strobe and ignore READY.
module bus_cycle_seq
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int N_IDLE      = 2,
    parameter bit FETCH_WAITS = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    input  logic                     ready,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [1:0]               status,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid,
    output logic [2:0]               tstate
);

    tstate_e           tst;
    cyc_e              cyc;
    logic              accept;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    bus_seq_tctl #(
        .N_IDLE      (N_IDLE),
        .FETCH_WAITS (FETCH_WAITS)
    ) u_tctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .ready     (ready),
        .tst       (tst),
        .cyc       (cyc),
        .req_ready (req_ready),
        .accept    (accept)
    );

    bus_seq_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q)
    );

    bus_seq_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .tst     (tst),
        .cyc     (cyc),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .status  (status),
        .addr_hi (addr_hi),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe)
    );

    bus_seq_rcap #(
        .DATA_W (DATA_W)
    ) u_rcap (
        .clk         (clk),
        .rst_n       (rst_n),
        .tst         (tst),
        .cyc         (cyc),
        .ad_in       (ad_in),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    assign tstate = 3'(tst);

endmodule

// File: rtl/bus_cycle_seq_chk.sv
// Checker: temporal properties over the sequencer's ports, bound to every
// instance of the top. Assumes the default in which fetches honour READY.
module bus_cycle_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       req_ready,
    input logic [2:0] tstate,
    input logic [1:0] status,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ad_oe,
    input logic       rdata_valid
);

    // R1: a reset edge leaves the bus quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (tstate == 3'd0) && !ale && rd_n && wr_n && !ad_oe && !rdata_valid);

    // R2: address latch strobe only in T1 of a real bus cycle
    a_r2_ale_in_t1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (tstate == 3'd1) && (status != 2'b00));

    // R3: fetch or read T3 is followed by a data-valid clock
    a_r3_capture_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd3) && status[1] |=> rdata_valid);

    // R4: read and write strobes never overlap
    a_r4_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R5: READY low in T2 or a wait state of a bus cycle gives a wait state
    a_r5_wait_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == 3'd2) || (tstate == 3'd5)) && (status != 2'b00) && !ready
        |=> (tstate == 3'd5));

    // R7: idle cycles keep every strobe and the data drive off
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate != 3'd0) && (status == 2'b00) |-> rd_n && wr_n && !ale && !ad_oe);

    // R8: idle cycles never wait
    a_r8_idle_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == 3'd2) && (status == 2'b00) |=> (tstate == 3'd3));

    // R9: requests are taken only with no cycle or in a closing T state
    a_r9_accept_point: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (tstate == 3'd0) || (tstate == 3'd3) || (tstate == 3'd4));

endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .req_ready   (req_ready),
    .tstate      (tstate),
    .status      (status),
    .ale         (ale),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .ad_oe       (ad_oe),
    .rdata_valid (rdata_valid)
);

// File: tb/bus_cycle_seq_tb.sv
// Bench: one negedge process drives reset, requests, READY and the bus data.
// At every acceptance, a behavioural model lays out the expected pin trace
// per slot, and the bench compares it against the pins on each clock.
`timescale 1ns/1ps
module bus_cycle_seq_tb;

    localparam int N_IDLE = 2;
    localparam int SLOTS  = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready;
    logic       ready = 1'b1;
    logic [7:0] ad_in = '0;
    logic       ale, rd_n, wr_n, ad_oe, rdata_valid;
    logic [1:0] status;
    logic [7:0] addr_hi, ad_out, rdata;
    logic [2:0] tstate;

    always #4 clk = ~clk;   // 125 MHz

    bus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .ready(ready), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .status(status), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .rdata(rdata), .rdata_valid(rdata_valid), .tstate(tstate)
    );

    typedef struct {
        int kind; int addr; int wdata; int gap;
        int lo_a; int lo_n; int lo2_a; int lo2_n;
    } item_t;
    typedef struct {
        int slot; int ts; int st; int ale; int rdn; int wrn;
        int oe; int ad; int hi; int rdy; string tag;
    } exp_t;
    typedef struct { int slot; int data; } rv_t;

    item_t prog[$];
    exp_t  eq[$];
    rv_t   rq[$];
    bit    ready_lo [0:SLOTS-1];
    int    phase = 0;
    int    checks = 0;
    int    fails = 0;
    int    tail = 0;
    bit    done = 1'b0;

    function automatic int adin_at(int m);
        return (m * 37 + 11) & 255;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(int slot, int ts, int st, int a, int rdn, int wrn,
                        int oe, int ad, int hi, string tag);
        exp_t e;
        e = '{slot, ts, st, a, rdn, wrn, oe, ad, hi, 0, tag};
        eq.push_back(e);
    endtask

    task automatic mark_low(int from, int len);
        for (int i = 0; i < len; i++)
            if (from + i < SLOTS) ready_lo[from + i] = 1'b1;
    endtask

    // Model: lay out the expected trace of a request taken at slot n.
    task automatic expand(int n, item_t it);
        int st, lo, hi, s, rdn, wrn, oe;
        string tg;
        mark_low(n + it.lo_a, it.lo_n);
        mark_low(n + it.lo2_a, it.lo2_n);
        st  = (it.kind == 1) ? 2 : (it.kind == 2) ? 1 : 3;
        tg  = (st == 3) ? "R2" : (st == 2) ? "R3" : "R4";
        lo  = it.addr & 255;
        hi  = (it.addr >> 8) & 255;
        rdn = (st == 1) ? 1 : 0;
        wrn = (st == 1) ? 0 : 1;
        oe  = (st == 1) ? 1 : 0;
        s = n + 1;
        push(s, 1, st, 1, 1, 1, 1, lo, hi, tg);
        s++;
        push(s, 2, st, 0, rdn, wrn, oe, it.wdata, hi, tg);
        while (s < SLOTS && ready_lo[s]) begin
            s++;
            push(s, 5, st, 0, rdn, wrn, oe, it.wdata, hi, "R5");
        end
        s++;
        push(s, 3, st, 0, rdn, wrn, oe, it.wdata, hi, tg);
        if (st != 1) rq.push_back('{s + 1, adin_at(s)});
        if (st == 3) begin
            s++;
            push(s, 4, st, 0, 1, 1, 0, 0, hi, tg);
        end
        if (it.kind == 3) begin
            for (int c = 0; c < N_IDLE; c++)
                for (int t = 1; t <= 3; t++) begin
                    s++;
                    // R6 sequence; T3 after a READY-low T2 is the R8 point
                    push(s, t, 0, 0, 1, 1, 0, 0, hi, (t == 3) ? "R8" : "R6");
                end
        end
        eq[eq.size() - 1].rdy = 1;   // R9: only the closing slot takes a request
    endtask

    // Compare every pin against the model's slot record.
    task automatic compare(int m);
        exp_t  e;
        string sg;
        if (eq.size() > 0 && eq[0].slot == m) e = eq.pop_front();
        else e = '{m, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R1"};
        sg = (e.st == 0 && e.ts != 0) ? "R7" : e.tag;
        chk(int'(tstate) == e.ts, e.tag, "tstate", tstate, e.ts);
        chk(int'(status) == e.st, e.tag, "status", status, e.st);
        chk(int'(ale) == e.ale, sg, "ale", ale, e.ale);
        chk(int'(rd_n) == e.rdn, sg, "rd_n", rd_n, e.rdn);
        chk(int'(wr_n) == e.wrn, sg, "wr_n", wr_n, e.wrn);
        chk(int'(ad_oe) == e.oe, sg, "ad_oe", ad_oe, e.oe);
        if (e.oe != 0) chk(int'(ad_out) == e.ad, e.tag, "ad_out", ad_out, e.ad);
        chk(int'(addr_hi) == e.hi, e.tag, "addr_hi", addr_hi, e.hi);
        chk(int'(req_ready) == e.rdy, "R9", "req_ready", req_ready, e.rdy);
        if (rq.size() > 0 && rq[0].slot == m) begin
            chk(rdata_valid == 1'b1, "R3", "rdata_valid", rdata_valid, 1);
            chk(int'(rdata) == rq[0].data, "R3", "rdata", rdata, rq[0].data);
            void'(rq.pop_front());
        end else begin
            chk(rdata_valid == 1'b0, "R3", "rdata_valid", rdata_valid, 0);
        end
    endtask

    initial begin
        // kind addr wdata gap lo_a lo_n lo2_a lo2_n
        prog.push_back('{0, 'h1234, 0,     2, 0, 0, 0, 0});  // R2 fetch
        prog.push_back('{1, 'h2001, 0,     0, 0, 0, 0, 0});  // R3 back-to-back read
        prog.push_back('{2, 'h3002, 'hA5,  0, 0, 0, 0, 0});  // R4 write
        prog.push_back('{1, 'h40F0, 0,     1, 2, 3, 0, 0});  // R5 read, 3 waits
        prog.push_back('{2, 'h5111, 'h5A,  0, 2, 2, 0, 0});  // R5 write, 2 waits
        prog.push_back('{0, 'h6000, 0,     0, 2, 1, 0, 0});  // R5 fetch, 1 wait
        prog.push_back('{3, 'h7ABC, 0,     2, 5, 8, 0, 0});  // R6 R8 READY low in idles
        prog.push_back('{1, 'h8123, 0,     0, 0, 0, 0, 0});  // R9 read after idles
        prog.push_back('{3, 'h9001, 0,     3, 2, 1, 7, 6});  // R6 wait then idles
        prog.push_back('{2, 'hA0A0, 'h3C,  0, 0, 0, 0, 0});  // R4 write after idles
        prog.push_back('{0, 'hBEEF, 0,     4, 0, 0, 0, 0});  // R2 after gap
    end

    // Single driver/monitor process, one step per clock.
    always @(negedge clk) begin
        if (!done) begin
            if (phase < 5) begin
                rst_n = 1'b0;
                if (phase >= 2) begin   // R1 in reset
                    chk(tstate == 3'd0, "R1", "tstate", tstate, 0);
                    chk(ale == 1'b0 && ad_oe == 1'b0, "R1", "ale|ad_oe", {ale, ad_oe}, 0);
                    chk(rd_n == 1'b1 && wr_n == 1'b1, "R1", "rd_n&wr_n", {rd_n, wr_n}, 3);
                    chk(rdata_valid == 1'b0, "R1", "rdata_valid", rdata_valid, 0);
                end
            end else if (phase == 5) begin
                rst_n = 1'b1;
            end else begin
                compare(phase);
                req_valid = 1'b0;
                if (prog.size() > 0) begin
                    if (prog[0].gap > 0) begin
                        prog[0].gap = prog[0].gap - 1;
                    end else begin
                        req_valid = 1'b1;
                        req_kind  = 2'(prog[0].kind);
                        req_addr  = 16'(prog[0].addr);
                        req_wdata = 8'(prog[0].wdata);
                        if (req_ready) begin
                            expand(phase, prog[0]);
                            void'(prog.pop_front());
                        end
                    end
                end
                ready = !(phase < SLOTS && ready_lo[phase]);
                ad_in = 8'(adin_at(phase));
                if (prog.size() == 0 && eq.size() == 0 && rq.size() == 0) begin
                    tail++;
                    if (tail > 4) done = 1'b1;
                end
                if (phase > 4000) begin
                    chk(1'b0, "R9", "watchdog", phase, 0);
                    done = 1'b1;
                end
            end
            phase++;
        end
    end

    initial begin
        wait (done);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule